// File: doc/BRIEF.md
# Receive Frame Filter with Locking Status Register

This block sits behind a receive MAC and decides, once per finished frame, whether the frame is worth reporting to the host. The MAC gives a one-cycle end-of-frame strobe together with the destination address, the byte count (FCS included, preamble excluded) and three fault flags: overflow, FCS mismatch and dribble. The block derives a short-frame flag from the byte count. It compares the destination with the station address under a programmable match mode. It then tests the frame's fault pattern against a set of per-class report bits held in a host-written command byte.

A frame that passes both tests is captured into a status byte and raises an interrupt request. The status byte carries a lock bit. While the lock is engaged, every later frame is dropped, so the host always reads the status of the frame that caused the interrupt. A host read of the status releases the lock and withdraws the interrupt. CRC checking, bit-level reception and buffering happen elsewhere and reach this block only as flags.

Top module: `rxf_judge`

## Requirements
- R1: After reset the status byte reads 0x80 (lock bit 7 set, all flags clear), the interrupt is low and the command byte is 0x00, so the receiver is disabled.
- R2: Command bits 7:6 select the match mode, and mode 0 reports no frame at all, whatever its address or faults.
- R3: In mode 1 a frame passes the address test whatever its destination.
- R4: In mode 2 a frame passes only if its destination equals the station address or is broadcast (all 48 bits set).
- R5: In mode 3 a frame passes only if its destination equals the station address or is multicast. The first transmitted byte sits in destination bits 47:40, and multicast means bit 40 is set.
- R6: A frame whose byte count is below MIN_LEN (default 64) is short. A reported short frame has status bit 3 set, and command bit 3 makes short frames reportable.
- R7: A frame is good when it is not short and has no FCS error, no overflow, and either no dribble or command bit 2 set. A reported good frame shows status bit 4, and command bit 5 makes good frames reportable.
- R8: Command bit 0 reports frames with overflow, bit 1 frames with an FCS error, and bit 4 frames without overflow. The status shows overflow in bit 0, FCS error in bit 1 and dribble in bit 2, with bits 6:5 always 0.
- R9: A reportable frame seen while the lock bit is 1 updates the status byte and clears bit 7 on the clock edge that samples the end-of-frame strobe, and the interrupt goes high on that same edge.
- R10: While the lock bit is 0, later frames leave the status byte and the interrupt unchanged. After a release, the next reportable frame is captured again.
- R11: A status read strobe sets the lock bit and drops the interrupt on the next edge, and leaves status bits 4:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte value |
| stat_re | input | 1 | Host status read strobe (releases the lock) |
| stat_rdata | output | 8 | Current status byte |
| station_addr | input | ADDR_W | Station address |
| frm_done | input | 1 | End-of-frame strobe, one cycle |
| frm_dest | input | ADDR_W | Destination address of the frame |
| frm_len | input | LEN_W | Frame byte count including FCS |
| frm_overflow | input | 1 | Buffer was not available to the receiver |
| frm_fcs_bad | input | 1 | FCS mismatch |
| frm_dribble | input | 1 | Frame ended off a byte boundary |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A wrong match or classification decision shows up on the edge after the end-of-frame strobe: an interrupt that should have stayed low, or a status byte with the wrong flags. A lock bit stuck in the wrong state shows up one frame later. Either a second frame overwrites the held status, or a frame after a read is never captured. Both failures show up within two frames. A read that fails to release the lock, or fails to drop the interrupt, is visible on the very next cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      MM_OFF       = 2'd0,
      MM_ANY       = 2'd1,
      MM_UNI_BCAST = 2'd2,
      MM_UNI_MCAST = 2'd3
   } match_mode_e;

   // per-class report selects, command bits 5:0
   typedef struct packed {
      logic good;      // bit 5
      logic no_ovf;    // bit 4
      logic short_f;   // bit 3
      logic drib_ok;   // bit 2
      logic fcs;       // bit 1
      logic ovf;       // bit 0
   } report_sel_t;

   // frame fault summary, status bits 4:0
   typedef struct packed {
      logic good;
      logic short_f;
      logic drib;
      logic fcs;
      logic ovf;
   } frame_flags_t;

   localparam int STAT_W    = 8;
   localparam int LOCK_BIT  = 7;

endpackage

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
   import rxf_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  match_mode_e       mode,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic [ADDR_W-1:0] dest,
   output logic              addr_ok
);
   localparam int NBYTES   = ADDR_W / 8;
   localparam int MCAST_IX = ADDR_W - 8;

   logic [NBYTES-1:0] byte_all_ones;
   logic              is_bcast;
   logic              is_mcast;
   logic              is_self;

   for (genvar b = 0; b < NBYTES; b++) begin : g_bc
      assign byte_all_ones[b] = &dest[b*8 +: 8];
   end

   assign is_bcast = &byte_all_ones;
   assign is_mcast = dest[MCAST_IX];
   assign is_self  = (dest == station_addr);

   always_comb begin
      unique case (mode)
         MM_OFF:       addr_ok = 1'b0;
         MM_ANY:       addr_ok = 1'b1;
         MM_UNI_BCAST: addr_ok = is_self | is_bcast;
         MM_UNI_MCAST: addr_ok = is_self | is_mcast;
         default:      addr_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
   import rxf_pkg::*;
#(
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 64
) (
   input  report_sel_t      sel,
   input  logic [LEN_W-1:0] len,
   input  logic             ovf,
   input  logic             fcs_bad,
   input  logic             dribble,
   output frame_flags_t     flags,
   output logic             wanted
);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

   logic is_short;
   logic is_good;

   assign is_short = (len < MIN_L);
   assign is_good  = ~is_short & ~fcs_bad & ~ovf & (~dribble | sel.drib_ok);

   always_comb begin
      flags.good    = is_good;
      flags.short_f = is_short;
      flags.drib    = dribble;
      flags.fcs     = fcs_bad;
      flags.ovf     = ovf;
   end

   assign wanted = (sel.ovf     & ovf)
                 | (sel.fcs     & fcs_bad)
                 | (sel.short_f & is_short)
                 | (sel.no_ovf  & ~ovf)
                 | (sel.good    & is_good);
endmodule

// File: rtl/rxf_status_latch.sv
module rxf_status_latch
   import rxf_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  frame_flags_t       flags,
   input  logic               stat_re,
   output logic [STAT_W-1:0]  stat,
   output logic               irq
);
   logic         lock_open;
   frame_flags_t held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_open <= 1'b1;
         held      <= '0;
         irq       <= 1'b0;
      end else if (stat_re) begin
         lock_open <= 1'b1;
         irq       <= 1'b0;
      end else if (take && lock_open) begin
         lock_open <= 1'b0;
         held      <= flags;
         irq       <= 1'b1;
      end
   end

   assign stat = {lock_open, 2'b00, held};
endmodule

// File: rtl/rxf_judge.sv
module rxf_judge
   import rxf_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [7:0]        cmd_wdata,
   input  logic              stat_re,
   output logic [7:0]        stat_rdata,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic              frm_done,
   input  logic [ADDR_W-1:0] frm_dest,
   input  logic [LEN_W-1:0]  frm_len,
   input  logic              frm_overflow,
   input  logic              frm_fcs_bad,
   input  logic              frm_dribble,
   output logic              rx_irq
);
   if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_addr
      $error("rxf_judge: ADDR_W must be a whole number of bytes, at least two");
   end
   if (MIN_LEN < 1 || MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("rxf_judge: MIN_LEN must fit in LEN_W bits");
   end

   logic [7:0]   cmd_q;
   logic         addr_ok;
   logic         wanted;
   logic         take;
   frame_flags_t flags;

   always_ff @(posedge clk) begin
      if (!rst_n)      cmd_q <= 8'h00;
      else if (cmd_we) cmd_q <= cmd_wdata;
   end

   rxf_addr_match #(.ADDR_W(ADDR_W)) u_match (
      .mode         (match_mode_e'(cmd_q[7:6])),
      .station_addr (station_addr),
      .dest         (frm_dest),
      .addr_ok      (addr_ok)
   );

   rxf_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_class (
      .sel     (report_sel_t'(cmd_q[5:0])),
      .len     (frm_len),
      .ovf     (frm_overflow),
      .fcs_bad (frm_fcs_bad),
      .dribble (frm_dribble),
      .flags   (flags),
      .wanted  (wanted)
   );

   assign take = frm_done & addr_ok & wanted;

   rxf_status_latch u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .flags   (flags),
      .stat_re (stat_re),
      .stat    (stat_rdata),
      .irq     (rx_irq)
   );
endmodule

// File: rtl/rxf_judge_chk.sv
module rxf_judge_chk #(
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       cmd_q,
   input logic             stat_re,
   input logic [7:0]       stat_rdata,
   input logic             frm_done,
   input logic [LEN_W-1:0] frm_len,
   input logic             rx_irq
);
   AST_IRQ_TRACKS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq == !stat_rdata[7]);                                            // R9
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rdata[7] && !stat_re) |=> $stable(stat_rdata));                // R10
   AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stat_re |=> (stat_rdata[7] && !rx_irq));                              // R11
   AST_READ_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_re |=> (stat_rdata[4:0] == $past(stat_rdata[4:0])));             // R11
   AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[7:6] == 2'd0 && stat_rdata[7]) |=> stat_rdata[7]);             // R2
   AST_CAPTURE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata[7] && !frm_done) |=> stat_rdata[7]);                      // R9
   AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata[7] && frm_done && !stat_re) ##1 !stat_rdata[7]
      |-> stat_rdata[3] == ($past(frm_len) < LEN_W'(MIN_LEN)));            // R6
   AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rdata[6:5] == 2'b00);                                            // R8
endmodule

bind rxf_judge rxf_judge_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_q      (cmd_q),
   .stat_re    (stat_re),
   .stat_rdata (stat_rdata),
   .frm_done   (frm_done),
   .frm_len    (frm_len),
   .rx_irq     (rx_irq)
);

// File: tb/rxf_judge_test.sv
module rxf_judge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [7:0]  cmd_wdata = 8'h00;
   logic        stat_re = 1'b0;
   logic [7:0]  stat_rdata;
   logic [47:0] station_addr = 48'h0260_8C12_3456;
   logic        frm_done = 1'b0;
   logic [47:0] frm_dest = '0;
   logic [10:0] frm_len = '0;
   logic        frm_overflow = 1'b0;
   logic        frm_fcs_bad = 1'b0;
   logic        frm_dribble = 1'b0;
   logic        rx_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rxf_judge uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .stat_re(stat_re), .stat_rdata(stat_rdata), .station_addr(station_addr),
      .frm_done(frm_done), .frm_dest(frm_dest), .frm_len(frm_len),
      .frm_overflow(frm_overflow), .frm_fcs_bad(frm_fcs_bad),
      .frm_dribble(frm_dribble), .rx_irq(rx_irq)
   );

   localparam logic [47:0] SELF  = 48'h0260_8C12_3456;
   localparam logic [47:0] OTHER = 48'h0800_2000_0001;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MCAST = 48'h0100_5E00_0001;

   typedef struct packed {
      logic [7:0]  cmd;
      logic [47:0] dest;
      logic [10:0] len;
      logic        ovf;
      logic        fcs;
      logic        drib;
      logic        take;
      logic [7:0]  stat;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{8'h60, OTHER, 11'd100, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10},  // R3
      '{8'h20, SELF,  11'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R2
      '{8'hA0, OTHER, 11'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R4
      '{8'hA0, BCAST, 11'd64,  1'b0, 1'b0, 1'b0, 1'b1, 8'h10},  // R4, R6 edge
      '{8'hA0, SELF,  11'd63,  1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R6, R7
      '{8'hA8, SELF,  11'd63,  1'b0, 1'b0, 1'b0, 1'b1, 8'h08},  // R6
      '{8'hE0, MCAST, 11'd100, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10},  // R5
      '{8'hE0, OTHER, 11'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R5
      '{8'hE0, BCAST, 11'd100, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10},  // R5
      '{8'hA0, SELF,  11'd100, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R7
      '{8'hA4, SELF,  11'd100, 1'b0, 1'b0, 1'b1, 1'b1, 8'h14},  // R7
      '{8'hA4, SELF,  11'd100, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},  // R7
      '{8'hA2, SELF,  11'd100, 1'b0, 1'b1, 1'b0, 1'b1, 8'h02},  // R8
      '{8'hA1, SELF,  11'd100, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01},  // R8
      '{8'hB0, SELF,  11'd100, 1'b0, 1'b1, 1'b0, 1'b1, 8'h02},  // R8
      '{8'hB0, SELF,  11'd100, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}   // R8
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_cmd(input logic [7:0] v);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic rd_stat();
      @(negedge clk); stat_re = 1'b1;
      @(negedge clk); stat_re = 1'b0;
   endtask

   task automatic send(input logic [47:0] d, input logic [10:0] l,
                       input logic o, input logic f, input logic b);
      @(negedge clk);
      frm_done = 1'b1; frm_dest = d; frm_len = l;
      frm_overflow = o; frm_fcs_bad = f; frm_dribble = b;
      @(negedge clk);
      frm_done = 1'b0; frm_overflow = 1'b0; frm_fcs_bad = 1'b0; frm_dribble = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(stat_rdata == 8'h80, "R1 status", stat_rdata, 8'h80);
      chk(rx_irq == 1'b0, "R1 irq", rx_irq, 0);
      // R1/R2: default command disables reception
      send(SELF, 11'd100, 1'b0, 1'b0, 1'b0);
      chk(rx_irq == 1'b0 && stat_rdata == 8'h80, "R1 R2 default off", stat_rdata, 8'h80);

      // table walk
      for (int i = 0; i < NV; i++) begin
         wr_cmd(VECS[i].cmd);
         rd_stat();
         send(VECS[i].dest, VECS[i].len, VECS[i].ovf, VECS[i].fcs, VECS[i].drib);
         if (VECS[i].take) begin
            chk(rx_irq == 1'b1, $sformatf("R9 vec%0d irq", i), rx_irq, 1);
            chk(stat_rdata == VECS[i].stat, $sformatf("R9 vec%0d status", i),
                stat_rdata, VECS[i].stat);
         end else begin
            chk(rx_irq == 1'b0 && stat_rdata[7],
                $sformatf("R2-class vec%0d no capture", i), {rx_irq, stat_rdata}, 8'h80);
         end
         rd_stat();
      end

      // R10 lock holds, R11 read releases
      wr_cmd(8'hAA);
      rd_stat();
      send(SELF, 11'd40, 1'b0, 1'b0, 1'b0);
      chk(stat_rdata == 8'h08 && rx_irq, "R9 short capture", stat_rdata, 8'h08);
      send(SELF, 11'd40, 1'b0, 1'b1, 1'b0);
      chk(stat_rdata == 8'h08, "R10 locked status", stat_rdata, 8'h08);
      chk(rx_irq == 1'b1, "R10 irq held", rx_irq, 1);
      rd_stat();
      chk(stat_rdata == 8'h88, "R11 release keeps flags", stat_rdata, 8'h88);
      chk(rx_irq == 1'b0, "R11 irq dropped", rx_irq, 0);
      send(SELF, 11'd40, 1'b0, 1'b1, 1'b0);
      chk(stat_rdata == 8'h0A && rx_irq, "R10 capture after release", stat_rdata, 8'h0A);

      // R1 reset in mid-operation
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk(stat_rdata == 8'h80 && !rx_irq, "R1 reset clears", stat_rdata, 8'h80);
      send(BCAST, 11'd100, 1'b0, 1'b0, 1'b0);
      chk(!rx_irq, "R1 command cleared", rx_irq, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule